// File: doc/BRIEF.md
# Weighted Pseudo-Random Bit-Stream Generator

This block feeds a built-in self-test pattern source with several pseudo-random bit-streams. Each stream has its own fixed probability of being 1. A hybrid rule 90/150 cellular automaton register supplies bits that are each close to 0.5 likely to be 1. Small fixed AND/OR networks then combine cells to move each stream to its target weight. The available weights are 1/2, 1/4, 5/8, 3/4, 7/8 and 15/16.

The streams advance on the test clock while `en_i` is high. An external tester can reseed the generator through a parallel load port, which replaces the whole automaton state in one clock. A packed parameter chooses the weight of each stream. The taps of every stream come from cells spread across the register, and no two taps share a cell, so the inputs of each gate are close to independent.

Top module: `wbs_gen`

## Requirements
- R1: While `rst_ni` is low, the automaton state is `RESET_SEED` (default 32'h1D2C_3B4A). The streams show that state as soon as reset is released.
- R2: When `seed_load_i` is high at a rising clock edge, the state becomes `seed_i` at that edge, whatever `en_i` is.
- R3: A load of the all-zero seed stores the value 1 instead: cell 0 is set and every other cell is clear.
- R4: When `en_i` is high and there is no load, each cell i takes the value (cell i-1) XOR (cell i+1) XOR (RULE_MASK[i] AND cell i). Cells past either end count as 0. The default RULE_MASK is 32'h6B5E_C3A9.
- R5: When both `en_i` and `seed_load_i` are low, the state and every stream hold their values.
- R6: Tap k of stream s is cell s + N_STREAMS*k. The 3-bit weight code of stream s is found at bits [3s+2:3s] of WEIGHT_CODES, and it sets the stream as follows:
  - code 0 (1/2): tap0
  - code 1 (1/4): tap0 AND tap1
  - code 2 (5/8): tap0 OR (tap1 AND tap2)
  - code 3 (3/4): tap0 OR tap1
  - code 4 (7/8): OR of taps 0 to 2
  - code 5 (15/16): OR of taps 0 to 3

  The streams are a combinational function of the current state. By default, stream s carries code s.
- R7: With `en_i` held high for 4096 cycles, each stream's count of ones is within 3% of its target weight times 4096.
- R8: The state is never all zero. If a step would produce the all-zero state, the value 1 is stored in its place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance the automaton one step per clock |
| seed_load_i | input | 1 | Load `seed_i` into the automaton |
| seed_i | input | CA_W | Parallel seed from the tester |
| stream_o | output | N_STREAMS | Weighted bit-streams, bit s is stream s |

## Verification
The automaton state cannot be read at the ports. Each stream shows only a lossy function of a few cells, so a wrong next-state term could go unseen for many cycles. To catch it, the bench loads seeds whose bit patterns it knows. It then steps a model of its own alongside the design and compares all six streams after every clock, so a wrong cell shows up within a few steps once it reaches any tap. The all-zero seed and the load that arrives while `en_i` is high are forced as directed cases, because random stimulus almost never produces them.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  // Weight codes for one stream
  localparam int unsigned W_HALF        = 0;
  localparam int unsigned W_QUARTER     = 1;
  localparam int unsigned W_FIVE_EIGHTH = 2;
  localparam int unsigned W_THREE_QUART = 3;
  localparam int unsigned W_SEVEN_EIGHT = 4;
  localparam int unsigned W_FIFTEEN_16  = 5;

  localparam int unsigned CODE_W   = 3;
  localparam int unsigned MAX_TAPS = 4;

  // Number of automaton cells a gate network of the given code reads
  function automatic int unsigned taps_for(input int unsigned code);
    case (code)
      W_HALF:        taps_for = 1;
      W_QUARTER:     taps_for = 2;
      W_FIVE_EIGHTH: taps_for = 3;
      W_THREE_QUART: taps_for = 2;
      W_SEVEN_EIGHT: taps_for = 3;
      default:       taps_for = 4;
    endcase
  endfunction

  // Target probability of a 1, in sixteenths
  function automatic int unsigned ones_in_16(input int unsigned code);
    case (code)
      W_HALF:        ones_in_16 = 8;
      W_QUARTER:     ones_in_16 = 4;
      W_FIVE_EIGHTH: ones_in_16 = 10;
      W_THREE_QUART: ones_in_16 = 12;
      W_SEVEN_EIGHT: ones_in_16 = 14;
      default:       ones_in_16 = 15;
    endcase
  endfunction

endpackage

// File: rtl/wbs_ca_core.sv
module wbs_ca_core #(
  parameter int unsigned    CA_W       = 32,
  parameter logic [CA_W-1:0] RULE_MASK  = 32'h6B5E_C3A9,
  parameter logic [CA_W-1:0] RESET_SEED = 32'h1D2C_3B4A
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            load_i,
  input  logic [CA_W-1:0] seed_i,
  output logic [CA_W-1:0] state_o
);

  localparam logic [CA_W-1:0] FILL = {{(CA_W-1){1'b0}}, 1'b1};

  logic [CA_W-1:0] state_q;
  logic [CA_W-1:0] step_val;
  logic [CA_W-1:0] state_d;
  logic            state_en;

  // Hybrid 90/150 step with null boundaries
  always_comb begin
    for (int i = 0; i < CA_W; i++) begin
      logic lft;
      logic rgt;
      lft = (i > 0)        ? state_q[(i > 0) ? i-1 : 0] : 1'b0;
      rgt = (i < CA_W - 1) ? state_q[(i < CA_W - 1) ? i+1 : i] : 1'b0;
      step_val[i] = lft ^ rgt ^ (RULE_MASK[i] & state_q[i]);
    end
  end

  // Next state: load wins over step, zero is never stored
  always_comb begin
    state_en = load_i | en_i;
    if (load_i) begin
      state_d = (seed_i == '0) ? FILL : seed_i;
    end else begin
      state_d = (step_val == '0) ? FILL : step_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RESET_SEED;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/wbs_weight_net.sv
module wbs_weight_net #(
  parameter int unsigned CODE = 0,
  localparam int unsigned NT  = wbs_pkg::taps_for(CODE)
) (
  input  logic [NT-1:0] taps_i,
  output logic          bit_o
);

  generate
    if (CODE == wbs_pkg::W_HALF) begin : g_half
      assign bit_o = taps_i[0];
    end else if (CODE == wbs_pkg::W_QUARTER) begin : g_quarter
      assign bit_o = &taps_i;
    end else if (CODE == wbs_pkg::W_FIVE_EIGHTH) begin : g_five8
      assign bit_o = taps_i[0] | (taps_i[1] & taps_i[NT-1]);
    end else begin : g_or
      assign bit_o = |taps_i;
    end
  endgenerate

endmodule

// File: rtl/wbs_gen.sv
module wbs_gen #(
  parameter int unsigned     CA_W         = 32,
  parameter int unsigned     N_STREAMS    = 6,
  parameter logic [CA_W-1:0] RULE_MASK    = 32'h6B5E_C3A9,
  parameter logic [CA_W-1:0] RESET_SEED   = 32'h1D2C_3B4A,
  parameter logic [N_STREAMS*wbs_pkg::CODE_W-1:0] WEIGHT_CODES =
    {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 seed_load_i,
  input  logic [CA_W-1:0]      seed_i,
  output logic [N_STREAMS-1:0] stream_o
);

  localparam int unsigned CW = wbs_pkg::CODE_W;

  initial begin
    if (CA_W < wbs_pkg::MAX_TAPS * N_STREAMS) begin
      $error("CA_W too small for disjoint taps");
    end
  end

  logic [CA_W-1:0] ca_q;

  wbs_ca_core #(
    .CA_W      (CA_W),
    .RULE_MASK (RULE_MASK),
    .RESET_SEED(RESET_SEED)
  ) core_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .load_i (seed_load_i),
    .seed_i (seed_i),
    .state_o(ca_q)
  );

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
    localparam int unsigned CODE = int'(WEIGHT_CODES[CW*s +: CW]);
    localparam int unsigned NT   = wbs_pkg::taps_for(CODE);
    logic [NT-1:0] taps;
    for (genvar k = 0; k < NT; k++) begin : g_tap
      assign taps[k] = ca_q[s + N_STREAMS*k];
    end
    wbs_weight_net #(.CODE(CODE)) net_i (
      .taps_i(taps),
      .bit_o (stream_o[s])
    );
  end

endmodule

// File: rtl/wbs_gen_chk.sv
module wbs_gen_chk #(
  parameter int unsigned     CA_W      = 32,
  parameter int unsigned     N_STREAMS = 6,
  parameter logic [CA_W-1:0] RULE_MASK = 32'h6B5E_C3A9,
  parameter logic [N_STREAMS*wbs_pkg::CODE_W-1:0] WEIGHT_CODES =
    {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 seed_load_i,
  input logic [CA_W-1:0]      seed_i,
  input logic [CA_W-1:0]      ca_q,
  input logic [N_STREAMS-1:0] stream_o
);

  localparam int unsigned CW = wbs_pkg::CODE_W;

  function automatic logic [CA_W-1:0] rule_step(input logic [CA_W-1:0] q);
    logic [CA_W-1:0] r;
    for (int i = 0; i < CA_W; i++) begin
      r[i] = ((i > 0) ? q[(i > 0) ? i-1 : 0] : 1'b0)
           ^ ((i < CA_W-1) ? q[(i < CA_W-1) ? i+1 : i] : 1'b0)
           ^ (RULE_MASK[i] & q[i]);
    end
    if (r == '0) r = {{(CA_W-1){1'b0}}, 1'b1};
    return r;
  endfunction

  p_seed_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_load_i && seed_i != '0) |=> ca_q == $past(seed_i));

  p_zero_seed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_load_i && seed_i == '0) |=> ca_q == {{(CA_W-1){1'b0}}, 1'b1});

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !seed_load_i) |=> ca_q == rule_step($past(ca_q)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !seed_load_i) |=> ($stable(ca_q) && $stable(stream_o)));

  p_never_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ca_q != '0);

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_map
    localparam int unsigned CODE = int'(WEIGHT_CODES[CW*s +: CW]);
    if (CODE == wbs_pkg::W_HALF) begin : g_h
      p_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stream_o[s] == ca_q[s]);
    end else if (CODE == wbs_pkg::W_QUARTER) begin : g_a
      p_and_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stream_o[s] |-> ca_q[s]);
    end else begin : g_o
      p_or_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ca_q[s] |-> stream_o[s]);
    end
  end

endmodule

bind wbs_gen wbs_gen_chk #(
  .CA_W        (CA_W),
  .N_STREAMS   (N_STREAMS),
  .RULE_MASK   (RULE_MASK),
  .WEIGHT_CODES(WEIGHT_CODES)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .seed_load_i(seed_load_i),
  .seed_i     (seed_i),
  .ca_q       (ca_q),
  .stream_o   (stream_o)
);

// File: tb/wbs_gen_tb.sv
module wbs_gen_tb_top;

  localparam int unsigned CA_W = 32;
  localparam int unsigned NS   = 6;
  localparam logic [31:0] RULE = 32'h6B5E_C3A9;
  localparam logic [31:0] RSTV = 32'h1D2C_3B4A;
  localparam logic [17:0] WC   = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          en_i;
  logic          seed_load_i;
  logic [31:0]   seed_i;
  logic [NS-1:0] stream_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] model_q;

  always #2.5 clk_i = ~clk_i;

  wbs_gen #(
    .CA_W(CA_W), .N_STREAMS(NS), .RULE_MASK(RULE),
    .RESET_SEED(RSTV), .WEIGHT_CODES(WC)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .seed_load_i(seed_load_i), .seed_i(seed_i), .stream_o(stream_o)
  );

  function automatic logic [31:0] model_step(input logic [31:0] q);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic l, h;
      l = (i == 0)  ? 1'b0 : q[(i == 0) ? 0 : i-1];
      h = (i == 31) ? 1'b0 : q[(i == 31) ? 31 : i+1];
      r[i] = l ^ h ^ (RULE[i] & q[i]);
    end
    return (r == 32'd0) ? 32'd1 : r;
  endfunction

  function automatic logic [NS-1:0] model_streams(input logic [31:0] q);
    logic [NS-1:0] o;
    for (int s = 0; s < NS; s++) begin
      logic t0, t1, t2, t3;
      t0 = q[s]; t1 = q[s+NS]; t2 = q[s+2*NS]; t3 = q[s+3*NS];
      case (int'(WC[3*s +: 3]))
        0:       o[s] = t0;
        1:       o[s] = t0 & t1;
        2:       o[s] = t0 | (t1 & t2);
        3:       o[s] = t0 | t1;
        4:       o[s] = t0 | t1 | t2;
        default: o[s] = t0 | t1 | t2 | t3;
      endcase
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; applies inputs for one rising edge, returns at next negedge
  task automatic step(input logic en, input logic ld, input logic [31:0] sd);
    en_i = en; seed_load_i = ld; seed_i = sd;
    @(posedge clk_i);
    if (ld)      model_q = (sd == 32'd0) ? 32'd1 : sd;
    else if (en) model_q = model_step(model_q);
    @(negedge clk_i);
  endtask

  initial begin
    logic [NS-1:0] held;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; en_i = 1'b0; seed_load_i = 1'b0; seed_i = '0;
    model_q = RSTV;
    repeat (3) @(negedge clk_i);
    check(stream_o == model_streams(RSTV), "R1 in reset", stream_o, model_streams(RSTV));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(stream_o == model_streams(RSTV), "R1 after release", stream_o, model_streams(RSTV));

    // R2: plain load
    step(1'b0, 1'b1, 32'hFFFF_FFFF);
    check(stream_o == 6'b111111, "R2 load all ones", stream_o, 6'b111111);
    // R2: load wins over enable
    step(1'b1, 1'b1, 32'h0000_0F00);
    check(stream_o == model_streams(32'h0000_0F00), "R2 load with en", stream_o,
          model_streams(32'h0000_0F00));
    // R3: zero seed becomes value 1, only stream 0 high
    step(1'b1, 1'b1, 32'd0);
    check(stream_o == 6'b000001, "R3 zero seed", stream_o, 6'b000001);
    step(1'b1, 1'b0, 32'd0);
    check(stream_o == model_streams(model_q), "R3 step after zero seed", stream_o,
          model_streams(model_q));

    // R5: hold with enable low, while seed_i toggles
    step(1'b0, 1'b1, 32'hA5A5_3C3C);
    held = stream_o;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, $urandom);
      check(stream_o == held, "R5 hold", stream_o, held);
    end
    step(1'b1, 1'b0, 32'd0);
    check(stream_o == model_streams(model_q), "R5 resume step", stream_o,
          model_streams(model_q));

    // R6: directed single-tap seeds per stream
    for (int s = 0; s < NS; s++) begin
      logic [31:0] sd;
      sd = 32'd1 << (s + NS);
      step(1'b0, 1'b1, sd);
      check(stream_o == model_streams(sd), "R6 single tap1", stream_o, model_streams(sd));
      sd = (32'd1 << (s + NS)) | (32'd1 << (s + 2*NS));
      step(1'b0, 1'b1, sd);
      check(stream_o == model_streams(sd), "R6 taps 1 and 2", stream_o, model_streams(sd));
    end

    // R4/R6: random mix of loads, steps and holds
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      step(r != 0, r == 1, (r == 1) ? $urandom : 32'd0);
      check(stream_o == model_streams(model_q), "R4 random step", stream_o,
            model_streams(model_q));
    end

    // R7/R8: density over 4096 enabled cycles
    begin
      int ones [NS];
      int toggles;
      logic prev0;
      step(1'b0, 1'b1, 32'h9E37_79B9);
      foreach (ones[s]) ones[s] = 0;
      toggles = 0;
      prev0 = stream_o[0];
      for (int i = 0; i < 4096; i++) begin
        step(1'b1, 1'b0, 32'd0);
        if (stream_o != model_streams(model_q))
          check(1'b0, "R4 density run", stream_o, model_streams(model_q));
        for (int s = 0; s < NS; s++) ones[s] += int'(stream_o[s]);
        if (stream_o[0] != prev0) toggles++;
        prev0 = stream_o[0];
      end
      for (int s = 0; s < NS; s++) begin
        int tgt, diff;
        tgt  = int'(wbs_pkg::ones_in_16(int'(WC[3*s +: 3]))) * 256;
        diff = ones[s] - tgt;
        if (diff < 0) diff = -diff;
        check(diff <= 122, "R7 density", ones[s], tgt);
      end
      check(toggles > 0, "R8 not stuck", toggles, 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule